// File: doc/BRIEF.md
# Velocity-Scaled Serial Audio DAC Driver

This block turns one 16-bit signed audio sample into the serial bit stream that a serial-input DAC expects. It sends sixteen data bits MSB first with a bit clock, then pulls a load line low so the converter latches the word. The key velocity that goes with each sample sets the loudness. The block does not use a multiplier or a barrel shifter for this. It holds its shift register still for a number of bit times chosen from the velocity, and during those bit times it repeats the sample's sign bit. The word the DAC receives is therefore an arithmetic right shift of the sample. The sample bits that no longer fit in sixteen are dropped.

An upstream voice generator presents a sample and its velocity on a valid/ready port. The upstream side sets the pace of the stream. Each transfer runs on its own and needs no timing relationship to the audio sample-rate clock. Back-pressure works like this: `s_ready` is high only while the serialiser is idle. A sample is taken on a rising `clk` edge where `s_valid` and `s_ready` are both high. While a transfer is running, `s_ready` stays low and the upstream side must hold its word, or withdraw it. Each bit lasts two `clk` cycles: one cycle with the bit clock low, then one cycle with it high. Data changes only when the bit clock falls.

Top module: `vel_serial_dac`

## Requirements
- R1: After reset, `s_ready` = 1, `dac_load_n` = 1, `dac_sck` = 0 and `dac_sdata` = 0.
- R2: A word is accepted on a rising edge with `s_valid` = 1 and `s_ready` = 1. `s_ready` is 0 from the next cycle for 32 cycles, and returns to 1 in the 33rd cycle after acceptance.
- R3: Each accepted word produces exactly sixteen bit periods. Each period is one `clk` cycle with `dac_sck` = 0 followed by one cycle with `dac_sck` = 1. The first low cycle is the cycle right after acceptance.
- R4: The sixteen bits read at the `dac_sck` high cycles, taken MSB first, equal the sample arithmetically shifted right by the attenuation amount, truncated to 16 bits.
- R5: The attenuation amount is 7 minus velocity bits [6:4]. Velocity 0x70–0x7F gives no shift and velocity 0x00–0x0F gives a shift of 7. Velocity bits [3:0] have no effect.
- R6: `dac_sdata` changes only in a cycle where `dac_sck` is 0, so it is stable while `dac_sck` is high.
- R7: `dac_load_n` is 1 from the cycle after acceptance through the last bit. It goes to 0 in the cycle after the sixteenth high phase (32 cycles after acceptance) and stays 0 until the next word is accepted.
- R8: Changing `s_sample`, `s_velocity` or `s_valid` during a transfer has no effect on that transfer's bits. A word offered while busy is not taken and is lost if it is withdrawn before `s_ready` rises.
- R9: If `s_valid` is held high, the next word is accepted on the edge where `s_ready` is first seen high again. Bit clocks start again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; two cycles per serial bit |
| rst_n | input | 1 | Active-low asynchronous reset |
| s_valid | input | 1 | Upstream sample valid |
| s_ready | output | 1 | Serialiser idle and able to take a sample |
| s_sample | input | 16 | Signed audio sample |
| s_velocity | input | 7 | Key velocity selecting attenuation |
| dac_sck | output | 1 | Serial bit clock to DAC |
| dac_sdata | output | 1 | Serial data, MSB first |
| dac_load_n | output | 1 | Active-low latch strobe to DAC |

## Verification
Every result is fixed relative to the acceptance edge E. The first bit clock low phase is at E+1. Bit k is high between E+2k+1 and E+2k+2. `s_ready` and `dac_load_n` change at E+32. The bench takes the acceptance edge as its reference and samples on each falling `clk` edge after it. Bits are read only on the falling edges where the bit clock must be high. Ready and the load line are checked on all 32 falling edges of the transfer and on the one after it. Anything the block should ignore is applied between those samples, and its lack of effect is judged from the bit stream and from the idle outputs that follow.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // Attenuation for one velocity index: full scale index maps to zero shift,
  // and adjacent index pairs share one entry.
  function automatic int unsigned atten_for_index(input int unsigned idx,
                                                  input int unsigned idx_w,
                                                  input int unsigned sh_w);
    int unsigned max_sh;
    max_sh = (1 << sh_w) - 1;
    return max_sh - (idx >> (idx_w - sh_w));
  endfunction
endpackage

// File: rtl/sdac_atten_lut.sv
module sdac_atten_lut
  import sdac_pkg::*;
#(
  parameter int VEL_W = 7,
  parameter int IDX_W = 4,
  parameter int SH_W  = 3
) (
  input  logic [VEL_W-1:0] velocity,
  output logic [SH_W-1:0]  shift_amt
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [SH_W-1:0]  table_q [ENTRIES];
  logic [IDX_W-1:0] index;

  assign index = velocity[VEL_W-1 -: IDX_W];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
    assign table_q[i] = SH_W'(atten_for_index(i, IDX_W, SH_W));
  end

  assign shift_amt = table_q[index];

  // R5: loudest velocity band never attenuates
  always_comb begin
    if (index == {IDX_W{1'b1}})
      a_r5_full_scale: assert (shift_amt == '0);
  end
endmodule

// File: rtl/sdac_bit_timer.sv
module sdac_bit_timer #(
  parameter int BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic sck_hi,
  output logic bit_done,
  output logic last_done
);
  localparam int CNT_W = $clog2(BITS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BITS - 1);

  logic             phase;
  logic [CNT_W-1:0] bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      phase   <= 1'b0;
      bit_cnt <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      phase   <= 1'b0;
      bit_cnt <= '0;
    end else if (busy) begin
      phase <= ~phase;
      if (phase) begin
        if (bit_cnt == LAST) busy <= 1'b0;
        else                 bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  assign sck_hi    = busy & phase;
  assign bit_done  = busy & phase;
  assign last_done = bit_done & (bit_cnt == LAST);

  // R2: a transfer ends only after its final bit
  a_r2_end_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_cnt) == LAST);
  // R3: a started transfer begins with the clock low
  a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !sck_hi);
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int SAMPLE_W = 16,
  parameter int SH_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [SAMPLE_W-1:0] sample,
  input  logic [SH_W-1:0]     shift_amt,
  input  logic                bit_done,
  output logic                msb
);
  logic [SAMPLE_W-1:0] shreg;
  logic [SH_W-1:0]     hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      hold  <= '0;
    end else if (load) begin
      shreg <= sample;
      hold  <= shift_amt;
    end else if (bit_done) begin
      if (hold != '0) hold  <= hold - 1'b1;
      else            shreg <= {shreg[SAMPLE_W-2:0], 1'b0};
    end
  end

  assign msb = shreg[SAMPLE_W-1];

  // R4: while sign fill is pending the register is frozen
  a_r4_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && bit_done && hold != '0) |=> $stable(shreg));
endmodule

// File: rtl/vel_serial_dac.sv
module vel_serial_dac #(
  parameter int SAMPLE_W = 16,
  parameter int VEL_W    = 7,
  parameter int IDX_W    = 4,
  parameter int SH_W     = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [SAMPLE_W-1:0] s_sample,
  input  logic [VEL_W-1:0]    s_velocity,
  output logic                dac_sck,
  output logic                dac_sdata,
  output logic                dac_load_n
);
  logic           busy;
  logic           accept;
  logic           bit_done;
  logic           last_done;
  logic           msb;
  logic [SH_W-1:0] shift_amt;

  assign s_ready = ~busy;
  assign accept  = s_valid & s_ready;

  sdac_atten_lut #(.VEL_W(VEL_W), .IDX_W(IDX_W), .SH_W(SH_W)) u_lut (
    .velocity  (s_velocity),
    .shift_amt (shift_amt)
  );

  sdac_bit_timer #(.BITS(SAMPLE_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .busy      (busy),
    .sck_hi    (dac_sck),
    .bit_done  (bit_done),
    .last_done (last_done)
  );

  sdac_shifter #(.SAMPLE_W(SAMPLE_W), .SH_W(SH_W)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .sample    (s_sample),
    .shift_amt (shift_amt),
    .bit_done  (bit_done),
    .msb       (msb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         dac_load_n <= 1'b1;
    else if (accept)    dac_load_n <= 1'b1;
    else if (last_done) dac_load_n <= 1'b0;
  end

  assign dac_sdata = busy & msb;

  // R6: data only moves while the bit clock is low
  a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dac_sdata) |-> !dac_sck);
  // R7: latch strobe only asserted while idle
  a_r7_load_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !dac_load_n |-> s_ready);
  // R7: acceptance releases the latch strobe
  a_r7_load_released: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> dac_load_n);
  // R2 / R8: once taken, no further word is offered acceptance
  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_ready);
endmodule

// File: tb/tb_vel_serial_dac.sv
module tb_vel_serial_dac;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_sample = '0;
  logic [6:0]  s_velocity = '0;
  logic        dac_sck, dac_sdata, dac_load_n;

  int n_checks = 0;
  int n_fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vel_serial_dac dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_sample(s_sample), .s_velocity(s_velocity), .dac_sck(dac_sck),
    .dac_sdata(dac_sdata), .dac_load_n(dac_load_n)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] expect_word(input logic [15:0] smp, input logic [6:0] vel);
    int sh;
    sh = 7 - int'(vel[6:4]);
    return 16'($signed(smp) >>> sh);
  endfunction

  // Drive a word and wait for the acceptance edge (returns just after it, at the falling edge).
  task automatic offer(input logic [15:0] smp, input logic [6:0] vel);
    @(negedge clk);
    s_sample = smp; s_velocity = vel; s_valid = 1'b1;
    while (!s_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  // Called at the first falling edge after acceptance; observes 32 + 1 falling edges.
  task automatic observe(input logic [15:0] expw, input string tag, input bit scramble);
    logic [15:0] got;
    int highs, bad_phase, bad_ready, bad_load;
    got = '0; highs = 0; bad_phase = 0; bad_ready = 0; bad_load = 0;
    for (int j = 0; j < 32; j++) begin
      if (j > 0) @(negedge clk);
      if (scramble) begin s_sample = ~s_sample; s_velocity = s_velocity ^ 7'h55; end
      if (dac_sck !== 1'(j % 2)) bad_phase++;
      if (dac_sck) begin got = {got[14:0], dac_sdata}; highs++; end
      if (s_ready !== 1'b0) bad_ready++;
      if (dac_load_n !== 1'b1) bad_load++;
    end
    check(highs == 16 && bad_phase == 0, {"R3 bit clock ", tag}, highs, 16);
    check(got == expw, {"R4/R5 stream ", tag}, got, expw);
    check(bad_ready == 0, {"R2 ready low ", tag}, bad_ready, 0);
    check(bad_load == 0, {"R7 load high ", tag}, bad_load, 0);
    @(negedge clk);
    check(s_ready === 1'b1, {"R2 ready back ", tag}, s_ready, 1);
    check(dac_load_n === 1'b0, {"R7 load low ", tag}, dac_load_n, 0);
  endtask

  task automatic t_reset();
    check(s_ready === 1'b1 && dac_load_n === 1'b1 && dac_sck === 1'b0 && dac_sdata === 1'b0,
          "R1 reset", {s_ready, dac_load_n, dac_sck, dac_sdata}, 4'b1100);
  endtask

  task automatic t_word(input logic [15:0] smp, input logic [6:0] vel, input string tag);
    offer(smp, vel);
    observe(expect_word(smp, vel), tag, 1'b0);
  endtask

  task automatic t_ignore_busy();
    logic [15:0] e;
    e = expect_word(16'h8123, 7'h7F);
    offer(16'h8123, 7'h7F);
    s_valid = 1'b1; // R8: offered while busy, withdrawn before ready
    observe(e, "R8 busy offer", 1'b1);
    s_valid = 1'b0;
    begin
      int edges;
      edges = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (dac_sck !== 1'b0 || dac_load_n !== 1'b0) edges++;
      end
      check(edges == 0, "R8 withdrawn word not sent", edges, 0);
    end
  endtask

  task automatic t_back_to_back();
    logic [15:0] e1, e2;
    e1 = expect_word(16'h4C3A, 7'h65);
    e2 = expect_word(16'hB5C7, 7'h12);
    offer(16'h4C3A, 7'h65);
    s_sample = 16'hB5C7; s_velocity = 7'h12; s_valid = 1'b1;
    observe(e1, "R9 first", 1'b0);
    @(posedge clk); // R9: accepted on the edge ready is seen high
    @(negedge clk);
    s_valid = 1'b0;
    check(dac_load_n === 1'b1 && s_ready === 1'b0, "R9 second taken", {dac_load_n, s_ready}, 2'b10);
    observe(e2, "R9 second", 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        t_word(16'h7FFF, 7'h7F, "R5 vel7F");
        t_word(16'hA5C3, 7'h70, "R5 vel70");
        t_word(16'hA5C3, 7'h00, "R5 vel00");
        t_word(16'h1234, 7'h48, "R5 vel48");
        t_word(16'h1234, 7'h40, "R5 vel40");
        t_word(16'h8000, 7'h2F, "R4 negmax");
        t_word(16'hFFFF, 7'h55, "R4 minus1");
        t_ignore_busy();
        t_back_to_back();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule